// File: doc/BRIEF.md
# Coded-Ratio Reference Clock Divider

This block brings a reference clock down to the rate at which a frequency synthesizer compares phase. The reference is not a clock of its own. It arrives as a one-cycle enable, `ref_en`, on the system clock `clk`, and each enabled cycle counts as one reference tick. A 4-bit ratio code picks the division ratio from a fixed set of sixteen values. The set is not uniform:

- Nine codes select powers of two, from 2 up to 512.
- Seven codes select three times a power of two, from 6 up to 384.

As an example, a 14 MHz reference divided by 64 gives a comparison rate of 218.75 kHz.

Each division period produces two outputs. `cmp_pulse_o` is a one-cycle pulse that marks the boundary between periods. `div_sq_o` is a square wave that is high for the first half of each period, with that half rounded down.

A new code is presented on `code_i` and accepted when `load_i` strobes. The running period always finishes at its old length, and the new ratio starts with the next period. Because of this, a change of ratio can never create a shortened or glitched period.

Top module: `refdiv_top`

## Requirements
- R1: Codes 0 to 8, read as a 4-bit unsigned value with bit 3 as the most significant bit, select ratio N = 2^(code+1): 2, 4, 8, 16, 32, 64, 128, 256, 512.
- R2: Codes 9 to 15 select ratio N = 3 * 2^(code-8): 6, 12, 24, 48, 96, 192, 384.
- R3: A code is captured when `load_i` is high for one cycle. It takes effect only from the next period boundary, so the period in progress keeps its old length. A change on `code_i` while `load_i` is low changes nothing.
- R4: One division period is exactly N reference ticks. `cmp_pulse_o` is high for exactly one `clk` cycle: the cycle that follows the tick which completes a period.
- R5: `div_sq_o` is high while the tick position within the period, counted from 0 at the boundary, is below floor(N/2), and low otherwise.
- R6: While `ref_en` is low, the period position is frozen. In that state `cmp_pulse_o` stays low and `div_sq_o` holds its value.
- R7: A synchronous active-high `rst` does the following:
  - clears the period position;
  - selects the ratio of code 0, which is 2;
  - clears any captured code;
  - drives `cmp_pulse_o` low and `div_sq_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | Reference tick enable, one cycle per reference edge |
| code_i | input | 4 | Ratio code |
| load_i | input | 1 | Strobe that captures `code_i` |
| cmp_pulse_o | output | 1 | One-cycle pulse at each period boundary |
| div_sq_o | output | 1 | Divided square output |

## Verification
The bench builds the block with the default package widths: a 4-bit code and a 10-bit ratio and position. With these widths every one of the sixteen codes can be reached, up to the 512-tick period. Every code is loaded in turn, and both the period length and the high time of the square output are measured from the outputs alone. Reference ticks are applied both on every cycle and on every second cycle. Further scenarios cover:

- a load part-way through a 512-tick period;
- a code change made without a strobe;
- a freeze of `ref_en`;
- a reset in the middle of a period.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int unsigned CODE_W    = 4;
    localparam int unsigned N_CODES   = 1 << CODE_W;
    localparam int unsigned POW2_LAST = 8;
    localparam int unsigned RATIO_W   = 10;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    // Period state: tick position and the ratio in force
    typedef struct packed {
        ratio_t pos;
        ratio_t ratio;
    } div_state_t;

    // Ratio selected for the next period, with its high-phase length
    typedef struct packed {
        ratio_t ratio;
        ratio_t half;
    } ratio_sel_t;

    // Power-of-two family below POW2_LAST+1, three-times family above
    function automatic ratio_t ratio_of(input int unsigned c);
        ratio_t r;
        if (c <= POW2_LAST) begin
            r = ratio_t'(2) << c;
        end else begin
            r = ratio_t'(3) << (c - POW2_LAST);
        end
        return r;
    endfunction

    localparam ratio_t RATIO_RST = ratio_of(0);
    localparam ratio_t RATIO_ONE = ratio_t'(1);

endpackage

// File: rtl/refdiv_code_reg.sv
module refdiv_code_reg
    import refdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  code_t code_i,
    output code_t sel_code_o
);

    code_t pend_q;
    code_t pend_d;

    // A strobe in the boundary cycle applies to the very next period
    always_comb begin
        pend_d = load_i ? code_i : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign sel_code_o = pend_d;

endmodule

// File: rtl/refdiv_ratio_lut.sv
module refdiv_ratio_lut
    import refdiv_pkg::*;
(
    input  code_t      code_i,
    output ratio_sel_t sel_o
);

    ratio_t table_w [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_entry
        assign table_w[g] = ratio_of(g);
    end

    always_comb begin
        sel_o.ratio = table_w[code_i];
        sel_o.half  = table_w[code_i] >> 1;
    end

endmodule

// File: rtl/refdiv_core.sv
module refdiv_core
    import refdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_en,
    input  ratio_sel_t next_sel_i,
    output div_state_t state_o,
    output logic       pulse_o,
    output logic       sq_o
);

    div_state_t st_q, st_d;
    logic       wrap;
    logic       sq_d;
    ratio_t     half_d;

    always_comb begin
        wrap   = ref_en && (st_q.pos == (st_q.ratio - RATIO_ONE));
        st_d   = st_q;
        half_d = st_q.ratio >> 1;
        if (ref_en) begin
            if (wrap) begin
                st_d.pos   = '0;
                st_d.ratio = next_sel_i.ratio;
                half_d     = next_sel_i.half;
            end else begin
                st_d.pos = st_q.pos + RATIO_ONE;
            end
        end
        sq_d = (st_d.pos < half_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pos   <= '0;
            st_q.ratio <= RATIO_RST;
            pulse_o    <= 1'b0;
            sq_o       <= 1'b1;
        end else begin
            st_q    <= st_d;
            pulse_o <= wrap;
            sq_o    <= sq_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_en,
    input  logic [3:0] code_i,
    input  logic       load_i,
    output logic       cmp_pulse_o,
    output logic       div_sq_o
);

    code_t      sel_code;
    ratio_sel_t next_sel;
    div_state_t state;
    ratio_t     cur_pos;
    ratio_t     cur_ratio;

    refdiv_code_reg u_code (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .code_i     (code_i),
        .sel_code_o (sel_code)
    );

    refdiv_ratio_lut u_lut (
        .code_i (sel_code),
        .sel_o  (next_sel)
    );

    refdiv_core u_core (
        .clk        (clk),
        .rst        (rst),
        .ref_en     (ref_en),
        .next_sel_i (next_sel),
        .state_o    (state),
        .pulse_o    (cmp_pulse_o),
        .sq_o       (div_sq_o)
    );

    assign cur_pos   = state.pos;
    assign cur_ratio = state.ratio;

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
    import refdiv_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   ref_en,
    input logic   cmp_pulse_o,
    input logic   div_sq_o,
    input ratio_t pos,
    input ratio_t ratio
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse_o |=> !cmp_pulse_o); // R4

    AST_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse_o |-> $past(ref_en)); // R4

    AST_FREEZE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> (!cmp_pulse_o && $stable(div_sq_o) && $stable(pos))); // R6

    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (!cmp_pulse_o && div_sq_o && pos == '0 && ratio == RATIO_RST)); // R7

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pos < ratio); // R4

    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ratio != $past(ratio)) |-> ($past(pos) == $past(ratio) - RATIO_ONE)); // R3

    AST_SQ_TRACKS_POS: assert property (@(posedge clk) disable iff (rst)
        div_sq_o == (pos < (ratio >> 1))); // R5

endmodule

bind refdiv_top refdiv_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_en      (ref_en),
    .cmp_pulse_o (cmp_pulse_o),
    .div_sq_o    (div_sq_o),
    .pos         (cur_pos),
    .ratio       (cur_ratio)
);

// File: tb/refdiv_top_tb_top.sv
module refdiv_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b1;
    logic [3:0] code_i = '0;
    logic       load_i = 1'b0;
    logic       cmp_pulse_o;
    logic       div_sq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refdiv_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .ref_en      (ref_en),
        .code_i      (code_i),
        .load_i      (load_i),
        .cmp_pulse_o (cmp_pulse_o),
        .div_sq_o    (div_sq_o)
    );

    function automatic int exp_ratio(input int c);
        if (c < 9) return 1 << (c + 1);
        return 3 << (c - 8);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic load_code(input int c);
        @(negedge clk);
        code_i = 4'(c);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic sync_pulse();
        int n = 0;
        ref_en = 1'b1;
        load_i = 1'b0;
        do begin
            @(negedge clk);
            n++;
        end while (!cmp_pulse_o && n < CAP);
        if (n >= CAP) check("R4 sync", 0, 1);
    endtask

    // Count cycles from one pulse to the next; en_div=2 ticks every other cycle
    task automatic measure(input int en_div, input int load_at, input int lcode,
                           output int cyc, output int hi);
        cyc = 0;
        hi  = 0;
        do begin
            ref_en = (en_div == 1) || (cyc % 2 == 1);
            load_i = (cyc == load_at);
            if (cyc == load_at) code_i = 4'(lcode);
            @(negedge clk);
            cyc++;
            if (div_sq_o) hi++;
        end while (!cmp_pulse_o && cyc < CAP);
        ref_en = 1'b1;
        load_i = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 reset pulse", int'(cmp_pulse_o), 0);
        check("R7 reset sq", int'(div_sq_o), 1);
        rst = 1'b0;
    endtask

    task automatic t_all_codes();
        int cyc, hi;
        for (int c = 0; c < 16; c++) begin
            load_code(c);
            sync_pulse();
            measure(1, -1, 0, cyc, hi);
            check(c < 9 ? "R1 period" : "R2 period", cyc, exp_ratio(c));
            check("R5 high time", hi, exp_ratio(c) / 2);
            @(negedge clk);
            check("R4 pulse width", int'(cmp_pulse_o), 0);
        end
    endtask

    task automatic t_gated_ticks();
        int cyc, hi;
        load_code(10);
        sync_pulse();
        measure(2, -1, 0, cyc, hi);
        check("R4 gated period", cyc, 2 * 12);
        check("R5 gated high", hi, 2 * 6);
    endtask

    task automatic t_deferred_load();
        int cyc, hi;
        load_code(8);
        sync_pulse();
        measure(1, 100, 0, cyc, hi);
        check("R3 period kept", cyc, 512);
        measure(1, -1, 0, cyc, hi);
        check("R3 new ratio", cyc, 2);
        code_i = 4'd15;
        measure(1, -1, 0, cyc, hi);
        check("R3 no strobe", cyc, 2);
        measure(1, -1, 0, cyc, hi);
        check("R3 no strobe again", cyc, 2);
    endtask

    task automatic t_freeze();
        logic sq0;
        int   pulses = 0;
        int   moved = 0;
        load_code(3);
        sync_pulse();
        repeat (5) @(negedge clk);
        sq0 = div_sq_o;
        ref_en = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (cmp_pulse_o) pulses++;
            if (div_sq_o != sq0) moved++;
        end
        ref_en = 1'b1;
        check("R6 no pulse", pulses, 0);
        check("R6 sq held", moved, 0);
    endtask

    task automatic t_mid_reset();
        int cyc, hi;
        load_code(15);
        sync_pulse();
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid pulse", int'(cmp_pulse_o), 0);
        check("R7 mid sq", int'(div_sq_o), 1);
        rst = 1'b0;
        measure(1, -1, 0, cyc, hi);
        check("R7 ratio after reset", cyc, 2);
        measure(1, -1, 0, cyc, hi);
        check("R7 code cleared", cyc, 2);
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: act=expired exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_all_codes();
        t_gated_ticks();
        t_deferred_load();
        t_freeze();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule